// File: doc/BRIEF.md
# Transport Stream Packet Synchronizer

This block takes a transport stream one byte per qualified cycle and works out where each fixed-length packet begins and ends. It marks the first byte of a packet with a start flag and the last byte with an end flag. A lock output reports whether the stream is trusted. The packet start can come from an external strobe, taken as a rising edge, a falling edge or a level, with selectable polarity. It can also come from a search for a configurable sync byte value, for sources that have no usable strobe. In that search mode, each packet boundary after the first is predicted from the packet length and then confirmed.

Lock is counted separately from framing. A programmable threshold sets how many sync byte values must be seen anywhere in the stream before lock is declared. A threshold of zero means the stream is always considered locked, whatever the data holds. Configuration is captured only while the block is hunting for a start. Each capture clears the lock count.

The control state machine has three states. HUNT waits for a start. BODY counts bytes inside a packet. EXPECT (byte-match mode only) checks the byte that should open the next packet. Its transitions are as follows:
- HUNT→BODY on a detected start.
- BODY→BODY on each further byte, or on a strobe restart.
- BODY→HUNT on the last byte in strobe modes.
- BODY→EXPECT on the last byte in byte-match mode.
- EXPECT→BODY when the sync value appears.
- EXPECT→HUNT on a mismatch.
- HUNT→EXPECT or EXPECT→EXPECT when a start byte is also the last byte, which happens for a length of one.

Top module: `ts_sync_aligner`

## Requirements
- R1: After reset, out_vld, out_sop, out_eop and locked are 0. The captured configuration is: sync value 0x47, packet length 188, lock threshold 1, strobe active high, mode 0.
- R2: out_byte and out_vld repeat byte_in and byte_vld one clock later. out_sop and out_eop are never 1 while out_vld is 0.
- R3: With a lock threshold of 0, locked is 1 in every cycle, including when the sync value never appears and when a byte-match boundary mismatches.
- R4: With a threshold N>0, locked rises in the same cycle as the Nth valid byte equal to the sync value appears on out_byte. The byte counts no matter where it falls in a packet.
- R5: Mode 0 (rising edge): a start is flagged on a valid byte whose effective strobe is 1 while the effective strobe of the previous valid byte was 0. A strobe held active flags only one start.
- R6: When cfg_act_low is 1, the effective strobe is the inverse of sop_strobe.
- R7: Mode 1 flags a start when the effective strobe falls from 1 to 0 between valid bytes. Mode 2 flags a start on every valid byte with the effective strobe at 1.
- R8: out_eop marks the byte at index L-1 counted from the start byte (index 0), where L is the length. In strobe modes, a new start inside a packet restarts the count, and bytes after the end that arrive without a start carry no flags.
- R9: Mode 3 (byte match) ignores the strobe. While hunting, a byte equal to the sync value opens a packet. The byte after an end must equal the sync value: if it does, it opens the next packet; if it does not, the lock count is cleared, that byte carries no start, and hunting resumes.
- R10: A cfg_load cycle while hunting captures the sync value from cfg_word[23:16], the length from cfg_word[15:4], the threshold from cfg_word[3:0], cfg_act_low and cfg_mode. It also clears the lock count and the strobe history and flags nothing. A cfg_load outside hunting has no effect.
- R11: Cycles with byte_vld at 0 flag nothing, count nothing and leave the strobe history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_in | input | 8 | Incoming stream byte |
| byte_vld | input | 1 | byte_in holds a byte this cycle |
| sop_strobe | input | 1 | External packet-start strobe |
| cfg_word | input | 24 | Sync value, packet length and lock threshold |
| cfg_act_low | input | 1 | Strobe polarity: 1 = active low |
| cfg_mode | input | 2 | Start source: 0 rise, 1 fall, 2 level, 3 byte match |
| cfg_load | input | 1 | Request to capture the configuration |
| out_byte | output | 8 | Registered stream byte |
| out_vld | output | 1 | out_byte is valid |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| locked | output | 1 | Stream is in sync |

## Verification
The hardest case to reach from the ports is loss of lock in byte-match mode. It needs a threshold above one, at least two complete packets framed by the predicted boundary, and then a corrupted byte placed exactly at the next predicted boundary. The stimulus builds two full packets with the strobe toggling throughout, so the strobe can be shown to have no effect. It then sends a filler byte where the sync value is due, and follows with a fresh search. A second hard case is a configuration request in the middle of a packet. Its rejection is made visible by asking for a shorter length and showing that the end flag still lands at the old length.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;

    localparam int unsigned TS_BYTE_W   = 8;
    localparam int unsigned TS_LEN_W    = 12;
    localparam int unsigned TS_NEED_W   = 4;
    localparam int unsigned TS_CFG_W    = TS_BYTE_W + TS_LEN_W + TS_NEED_W;
    localparam int unsigned TS_SYNC_LSB = TS_LEN_W + TS_NEED_W;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_BODY   = 2'd1,
        ST_EXPECT = 2'd2
    } ts_state_e;

    typedef enum logic [1:0] {
        MD_RISE  = 2'd0,
        MD_FALL  = 2'd1,
        MD_LEVEL = 2'd2,
        MD_MATCH = 2'd3
    } ts_mode_e;

    typedef struct packed {
        logic [TS_BYTE_W-1:0] sync;
        logic [TS_LEN_W-1:0]  len;
        logic [TS_NEED_W-1:0] need;
        logic                 act_low;
        ts_mode_e             mode;
    } ts_cfg_t;

    localparam ts_cfg_t TS_CFG_RESET = '{
        sync:    8'h47,
        len:     12'd188,
        need:    4'd1,
        act_low: 1'b0,
        mode:    MD_RISE
    };

endpackage

// File: rtl/ts_cfg_hold.sv
module ts_cfg_hold
    import ts_sync_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TS_CFG_W-1:0] cfg_word,
    input  logic                cfg_act_low,
    input  logic [1:0]          cfg_mode,
    input  logic                load_req,
    input  logic                idle,
    output ts_cfg_t             cfg_q,
    output logic                load_taken
);

    assign load_taken = load_req && idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= TS_CFG_RESET;
        end else if (load_taken) begin
            cfg_q.sync    <= cfg_word[TS_CFG_W-1 -: TS_BYTE_W];
            cfg_q.len     <= cfg_word[TS_SYNC_LSB-1 -: TS_LEN_W];
            cfg_q.need    <= cfg_word[TS_NEED_W-1:0];
            cfg_q.act_low <= cfg_act_low;
            cfg_q.mode    <= ts_mode_e'(cfg_mode);
        end
    end

    // R10: captured settings move only after a hunting cycle
    a_r10_cfg_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(idle));

endmodule

// File: rtl/ts_start_detect.sv
module ts_start_detect
    import ts_sync_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  ts_cfg_t              cfg,
    input  ts_state_e            state,
    input  logic                 proc,
    input  logic                 clr,
    input  logic [TS_BYTE_W-1:0] byte_in,
    input  logic                 strobe,
    output logic                 start,
    output logic                 mismatch,
    output logic                 hit
);

    logic adj;
    logic prev_q;
    logic eq;

    assign adj = strobe ^ cfg.act_low;
    assign eq  = (byte_in == cfg.sync);
    assign hit = proc && eq;

    always_comb begin
        start    = 1'b0;
        mismatch = 1'b0;
        unique case (cfg.mode)
            MD_RISE:  start = proc && adj && !prev_q;
            MD_FALL:  start = proc && !adj && prev_q;
            MD_LEVEL: start = proc && adj;
            MD_MATCH: begin
                start    = hit && (state != ST_BODY);
                mismatch = proc && !eq && (state == ST_EXPECT);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (clr) begin
            prev_q <= 1'b0;
        end else if (proc) begin
            prev_q <= adj;
        end
    end

    // R5: an edge start cannot repeat on the very next cycle
    a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MD_RISE && start) |=> !start);

endmodule

// File: rtl/ts_lock_track.sv
module ts_lock_track
    import ts_sync_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TS_NEED_W-1:0] need,
    input  logic                 hit,
    input  logic                 miss,
    input  logic                 clr,
    output logic                 locked
);

    logic [TS_NEED_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || miss) begin
            cnt_q <= '0;
        end else if (hit && (cnt_q < need)) begin
            cnt_q <= cnt_q + TS_NEED_W'(1);
        end
    end

    assign locked = (need == '0) || (cnt_q >= need);

    // R4: the count saturates at the threshold
    a_r4_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= need);

    // R9: a boundary mismatch drops lock when a threshold is set
    a_r9_miss_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !clr && need != '0) |=> !locked);

    // R10: applying configuration empties the count
    a_r10_clear_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/ts_sync_aligner.sv
module ts_sync_aligner
    import ts_sync_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TS_BYTE_W-1:0] byte_in,
    input  logic                 byte_vld,
    input  logic                 sop_strobe,
    input  logic [TS_CFG_W-1:0]  cfg_word,
    input  logic                 cfg_act_low,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_load,
    output logic [TS_BYTE_W-1:0] out_byte,
    output logic                 out_vld,
    output logic                 out_sop,
    output logic                 out_eop,
    output logic                 locked
);

    ts_cfg_t              cfg;
    ts_state_e            state_q, state_d;
    logic [TS_LEN_W-1:0]  idx_q, idx_d, pos, last_idx;
    logic                 load_taken, proc, start, mismatch, hit;
    logic                 in_pkt, last;

    assign proc = byte_vld && !load_taken;

    ts_cfg_hold u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_word    (cfg_word),
        .cfg_act_low (cfg_act_low),
        .cfg_mode    (cfg_mode),
        .load_req    (cfg_load),
        .idle        (state_q == ST_HUNT),
        .cfg_q       (cfg),
        .load_taken  (load_taken)
    );

    ts_start_detect u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .state    (state_q),
        .proc     (proc),
        .clr      (load_taken),
        .byte_in  (byte_in),
        .strobe   (sop_strobe),
        .start    (start),
        .mismatch (mismatch),
        .hit      (hit)
    );

    ts_lock_track u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .need   (cfg.need),
        .hit    (hit),
        .miss   (mismatch),
        .clr    (load_taken),
        .locked (locked)
    );

    assign last_idx = cfg.len - TS_LEN_W'(1);
    assign pos      = start ? '0 : idx_q;
    assign in_pkt   = start || (proc && state_q == ST_BODY);
    assign last     = in_pkt && (pos == last_idx);

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_HUNT, ST_BODY: begin
                if (last) begin
                    state_d = (cfg.mode == MD_MATCH) ? ST_EXPECT : ST_HUNT;
                end else if (in_pkt) begin
                    state_d = ST_BODY;
                    idx_d   = pos + TS_LEN_W'(1);
                end
            end
            ST_EXPECT: begin
                if (mismatch) begin
                    state_d = ST_HUNT;
                end else if (last) begin
                    state_d = ST_EXPECT;
                end else if (start) begin
                    state_d = ST_BODY;
                    idx_d   = TS_LEN_W'(1);
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_byte <= '0;
            out_vld  <= 1'b0;
            out_sop  <= 1'b0;
            out_eop  <= 1'b0;
        end else begin
            out_byte <= byte_in;
            out_vld  <= byte_vld;
            out_sop  <= start;
            out_eop  <= last;
        end
    end

    // R2: flags only ride on valid bytes
    a_r2_flags_need_vld: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_vld);

    // R9: in byte-match mode every flagged start carries the sync value
    a_r9_sop_is_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop && cfg.mode == MD_MATCH) |-> (out_byte == cfg.sync));

    // R8: the byte index stays inside the programmed length
    a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY) |-> (cfg.len == '0 || idx_q < cfg.len));

endmodule

// File: tb/tb_ts_sync_aligner.sv
module tb_ts_sync_aligner;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  byte_in = '0;
    logic        byte_vld = 1'b0;
    logic        sop_strobe = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        cfg_act_low = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_load = 1'b0;
    logic [7:0]  out_byte;
    logic        out_vld, out_sop, out_eop, locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_state = 0, m_idx = 0, m_cnt = 0;
    bit m_prev = 0;
    int m_sync = 8'h47, m_len = 188, m_need = 1, m_mode = 0;
    bit m_low = 0;
    int e_byte = 0;
    bit e_vld = 0, e_sop = 0, e_eop = 0, e_locked = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_sync_aligner dut (
        .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
        .sop_strobe(sop_strobe), .cfg_word(cfg_word), .cfg_act_low(cfg_act_low),
        .cfg_mode(cfg_mode), .cfg_load(cfg_load), .out_byte(out_byte),
        .out_vld(out_vld), .out_sop(out_sop), .out_eop(out_eop), .locked(locked)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_step(bit v, int b, bit s, bit ld);
        bit adj, eq, st, mis, inpkt, last;
        int pos;
        e_vld = v; e_byte = b; e_sop = 0; e_eop = 0;
        if (ld && m_state == 0) begin
            m_sync = cfg_word[23:16]; m_len = cfg_word[15:4]; m_need = cfg_word[3:0];
            m_low = cfg_act_low; m_mode = cfg_mode; m_cnt = 0; m_prev = 0;
        end else if (v) begin
            adj = s ^ m_low;
            eq  = (b == m_sync);
            mis = 0;
            case (m_mode)
                0: st = adj && !m_prev;
                1: st = !adj && m_prev;
                2: st = adj;
                default: begin
                    st  = eq && (m_state != 1);
                    mis = !eq && (m_state == 2);
                end
            endcase
            m_prev = adj;
            if (mis) m_cnt = 0;
            else if (eq && m_cnt < m_need) m_cnt++;
            pos   = st ? 0 : m_idx;
            inpkt = st || (m_state == 1);
            last  = inpkt && (pos == ((m_len - 1) & 4095));
            e_sop = st; e_eop = last;
            if (mis) m_state = 0;
            else if (last) m_state = (m_mode == 3) ? 2 : 0;
            else if (inpkt) begin m_state = 1; m_idx = pos + 1; end
        end
        e_locked = (m_need == 0) || (m_cnt >= m_need);
    endtask

    task automatic drive(bit v, bit [7:0] b, bit s, bit ld, string req);
        byte_vld = v; byte_in = b; sop_strobe = s; cfg_load = ld;
        @(posedge clk);
        model_step(v, b, s, ld);
        @(negedge clk);
        chk(req, "out_vld", out_vld, e_vld);
        chk(req, "out_byte", out_byte, e_byte);
        chk(req, "out_sop", out_sop, e_sop);
        chk(req, "out_eop", out_eop, e_eop);
        chk(req, "locked", locked, e_locked);
    endtask

    task automatic send(bit [7:0] b, bit s, string req);
        drive(1, b, s, 0, req);
    endtask

    task automatic gap(bit s, string req);
        drive(0, 8'h00, s, 0, req);
    endtask

    task automatic fill(int n, bit s, string req);
        for (int k = 0; k < n; k++) send(8'(8'h10 + k % 32), s, req);
    endtask

    task automatic load(bit [7:0] sy, int len, int need, bit low, int mode, string req);
        cfg_word = {sy, 12'(len), 4'(need)};
        cfg_act_low = low; cfg_mode = 2'(mode);
        drive(0, 8'h00, 0, 1, req);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "out_vld", out_vld, 0);
        chk("R1", "out_sop", out_sop, 0);
        chk("R1", "out_eop", out_eop, 0);
        chk("R1", "locked", locked, 0);
        rst_n = 1'b1;

        // R1/R4/R5/R8: default settings, 188-byte packet, sync at start locks
        send(8'h47, 1, "R5");
        fill(90, 0, "R8");
        gap(0, "R11");
        fill(97, 0, "R8");
        fill(2, 0, "R8");

        // R10: shorter packets, threshold 3
        load(8'h47, 6, 3, 0, 0, "R10");
        send(8'h11, 1, "R5");
        send(8'h47, 1, "R5");
        send(8'h12, 1, "R5");
        send(8'h47, 0, "R4");
        send(8'h13, 1, "R8");
        send(8'h47, 0, "R4");
        fill(4, 0, "R8");
        // R11: invalid cycles do not move the strobe history
        send(8'h14, 1, "R11");
        gap(0, "R11");
        send(8'h15, 1, "R11");
        // R10: a load mid-packet asking for length 2 is ignored
        cfg_word = {8'h47, 12'd2, 4'd0};
        drive(0, 8'h00, 0, 1, "R10");
        gap(0, "R11");
        fill(4, 0, "R10");

        // R6/R3: active-low strobe, threshold 0, no sync bytes
        load(8'h47, 4, 0, 1, 0, "R6");
        send(8'h16, 1, "R6");
        send(8'h17, 0, "R6");
        fill(3, 0, "R3");
        send(8'h18, 1, "R3");

        // R7: falling-edge mode
        load(8'h47, 4, 1, 0, 1, "R7");
        send(8'h19, 1, "R7");
        send(8'h1A, 0, "R7");
        fill(3, 0, "R7");
        // R7: level mode
        load(8'h47, 4, 1, 0, 2, "R7");
        send(8'h1B, 1, "R7");
        send(8'h1C, 1, "R7");
        fill(3, 0, "R7");

        // R9: byte-match mode, threshold 2, strobe toggling ignored
        load(8'hB8, 5, 2, 0, 3, "R9");
        fill(3, 1, "R9");
        send(8'hB8, 0, "R9");
        fill(4, 1, "R9");
        send(8'hB8, 1, "R9");
        fill(4, 0, "R9");
        send(8'h20, 1, "R9");
        fill(2, 0, "R9");
        send(8'hB8, 0, "R9");
        fill(4, 0, "R9");
        send(8'h21, 0, "R9");

        // R3: length 1 in byte-match mode, mismatch keeps lock with threshold 0
        load(8'hB8, 1, 0, 0, 3, "R3");
        send(8'hB8, 0, "R3");
        send(8'hB8, 0, "R3");
        send(8'h22, 0, "R3");
        send(8'hB8, 0, "R3");
        gap(0, "R2");

        summary();
    end

endmodule